// File: doc/BRIEF.md
# PHY Test-Port Write Sequencer

This block writes one internal configuration register of a PHY through its slow, strobe-based test port. The caller presents an 8-bit register code and an 8-bit value together with a one-cycle start request. The sequencer then steps the port's clear line, strobe line, enable line and shared data bus through a fixed order. The register code is latched by the PHY on a falling strobe edge while enable is high. The value is latched on the following rising strobe edge while enable is low. A clear phase always comes first. Every step is held for `STEP_CYCLES` system clocks so that the port's setup and hold times are met.

The port is presented as two words, which a neighbouring register shim can forward without change. The control word carries the clear line at bit 0 and the strobe at bit 1. The data word carries enable at bit `EN_BIT` (16 by default) and the code or value in its low bits. A typical use writes the link-rate band setting to register code 0x44 before a receiver is brought up.

States, in order: `ST_IDLE`, `ST_CLR_HI`, `ST_CLR_LO`, `ST_STB_UP`, `ST_ADDR_SET`, `ST_ADDR_FALL`, `ST_DATA_SET`, `ST_DATA_RISE`, `ST_STB_END`, `ST_DONE`. The transitions are as follows. `ST_IDLE` goes to `ST_CLR_HI` on a start request. Each of the eight step states moves to the next one in the list once its hold count expires. `ST_STB_END` goes to `ST_DONE`. `ST_DONE` returns unconditionally to `ST_IDLE` after one cycle.

Top module: `phy_test_writer`

## Requirements
- R1: While reset is asserted, and afterwards until a start is accepted, every output is zero.
- R2: An accepted write begins with a step in which clear (control bit 0) is 1, strobe is 0 and the data word is zero. This is followed by a step in which both control bits and the data word are zero.
- R3: The address phase follows. First comes a step with strobe high and the data word zero. Next comes a step with strobe high, enable (word bit 16) set and the code in word bits 7:0. Last comes a step with strobe low and the enable and code held, so the code is latched on the falling edge.
- R4: The data phase follows. First comes a step with strobe low, enable clear and the value in word bits 7:0. Next comes a step with strobe high and the value held, so it is latched on the rising edge. Last comes a step with strobe low and the value still held.
- R5: Each of the eight steps lasts exactly `STEP_CYCLES` clock cycles. The first step starts in the cycle after the start request is sampled.
- R6: `done_o` is high for exactly one cycle, immediately after the last step, with the control word and the data word both zero. `busy_o` is high from the first step up to and including the done cycle.
- R7: A start request sampled while `busy_o` is high, including in the done cycle, is ignored. The write in progress is unchanged and no further write follows it.
- R8: Control bits other than 0 and 1 do not exist. Data word bits between the operand field and the enable bit are always zero.
- R9: The code and value are captured when the start request is accepted. Later changes on `code_i` or `data_i` do not affect the write in progress.
- R10: A start request held high continuously produces back-to-back writes separated by exactly one idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Write request, sampled only when idle |
| code_i | input | CODE_W | PHY register code to write |
| data_i | input | DATA_W | Value to write |
| tst_ctrl_o | output | 2 | Test port control: bit 0 clear, bit 1 strobe |
| tst_word_o | output | EN_BIT+1 | Test port data word: bit EN_BIT enable, low bits code or value |
| busy_o | output | 1 | Write in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds two copies side by side from the same stimulus. One copy uses `STEP_CYCLES = 1`, which selects the timer variant without a counter and packs a whole write into nine cycles. The other uses `STEP_CYCLES = 3`, which exercises the counter wrap and allows the bench to observe hold behaviour inside a step. Because the two copies finish at different times, a single start pulse lands in a busy copy and an idle copy at once, so the ignore path and the accept path are exercised together. Code 0x44 and all-zero and all-one operands are driven to expose field placement errors.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [3:0] {
        ST_IDLE      = 4'd0,
        ST_CLR_HI    = 4'd1,
        ST_CLR_LO    = 4'd2,
        ST_STB_UP    = 4'd3,
        ST_ADDR_SET  = 4'd4,
        ST_ADDR_FALL = 4'd5,
        ST_DATA_SET  = 4'd6,
        ST_DATA_RISE = 4'd7,
        ST_STB_END   = 4'd8,
        ST_DONE      = 4'd9
    } ptw_state_e;

    // Control word bit positions (decoded by the register shim)
    localparam int CTRL_CLR_BIT = 0;
    localparam int CTRL_STB_BIT = 1;
    localparam int CTRL_W       = 2;

    // Register code of the link-rate band setting
    localparam logic [7:0] FREQ_RANGE_CODE = 8'h44;

    // Successor of a timed step once its hold count expires
    function automatic ptw_state_e ptw_step_succ(input ptw_state_e s);
        ptw_state_e n;
        unique case (s)
            ST_CLR_HI:    n = ST_CLR_LO;
            ST_CLR_LO:    n = ST_STB_UP;
            ST_STB_UP:    n = ST_ADDR_SET;
            ST_ADDR_SET:  n = ST_ADDR_FALL;
            ST_ADDR_FALL: n = ST_DATA_SET;
            ST_DATA_SET:  n = ST_DATA_RISE;
            ST_DATA_RISE: n = ST_STB_END;
            ST_STB_END:   n = ST_DONE;
            default:      n = ST_IDLE;
        endcase
        return n;
    endfunction

    function automatic logic ptw_is_timed(input ptw_state_e s);
        return (s != ST_IDLE) && (s != ST_DONE);
    endfunction

endpackage

// File: rtl/ptw_operand_reg.sv
module ptw_operand_reg #(
    parameter int CODE_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [CODE_W-1:0] code_q,
    output logic [DATA_W-1:0] data_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            data_q <= '0;
        end else if (load_i) begin
            code_q <= code_i;
            data_q <= data_i;
        end
    end

endmodule

// File: rtl/ptw_step_timer.sv
module ptw_step_timer #(
    parameter int STEP_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic last_o
);

    generate
        if (STEP_CYCLES <= 1) begin : g_single
            // Every timed step lasts one cycle: no counter needed
            logic unused_clk_rst;
            assign unused_clk_rst = &{1'b0, clk, rst_n};
            assign last_o = run_i;
        end else begin : g_count
            localparam int CNT_W = $clog2(STEP_CYCLES);
            localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(STEP_CYCLES - 1);

            logic [CNT_W-1:0] cnt_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (!run_i || (cnt_q == LAST_CNT)) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign last_o = run_i && (cnt_q == LAST_CNT);
        end
    endgenerate

endmodule

// File: rtl/ptw_seq_fsm.sv
module ptw_seq_fsm
    import ptw_pkg::*;
#(
    parameter int CODE_W = 8,
    parameter int DATA_W = 8,
    parameter int OPND_W = 8,
    parameter int EN_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              step_last_i,
    input  logic [CODE_W-1:0] code_q,
    input  logic [DATA_W-1:0] data_q,
    output logic              run_o,
    output logic              load_o,
    output logic [CTRL_W-1:0] tst_ctrl_o,
    output logic [EN_BIT:0]   tst_word_o,
    output logic              busy_o,
    output logic              done_o
);

    localparam int WORD_W  = EN_BIT + 1;
    localparam int SPARE_W = EN_BIT - OPND_W;

    ptw_state_e state_q, state_nxt;

    logic [OPND_W-1:0] code_ext, data_ext;
    logic [WORD_W-1:0] word_code, word_data;

    assign code_ext  = OPND_W'(code_q);
    assign data_ext  = OPND_W'(data_q);
    assign word_code = {1'b1, {SPARE_W{1'b0}}, code_ext};
    assign word_data = {1'b0, {SPARE_W{1'b0}}, data_ext};

    assign run_o  = ptw_is_timed(state_q);
    assign load_o = (state_q == ST_IDLE) && start_i;

    // Next-state logic
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_nxt = ST_CLR_HI;
            end
            ST_DONE: begin
                state_nxt = ST_IDLE;
            end
            default: begin
                if (step_last_i) state_nxt = ptw_step_succ(state_q);
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nxt;
    end

    // Output decode of the coming state, registered so lines never glitch
    logic [CTRL_W-1:0] ctrl_d;
    logic [WORD_W-1:0] word_d;
    logic              busy_d, done_d;

    always_comb begin
        ctrl_d = '0;
        word_d = '0;
        busy_d = 1'b1;
        done_d = 1'b0;
        unique case (state_nxt)
            ST_IDLE:      busy_d = 1'b0;
            ST_CLR_HI:    ctrl_d[CTRL_CLR_BIT] = 1'b1;
            ST_CLR_LO:    ;
            ST_STB_UP:    ctrl_d[CTRL_STB_BIT] = 1'b1;
            ST_ADDR_SET: begin
                ctrl_d[CTRL_STB_BIT] = 1'b1;
                word_d = word_code;
            end
            ST_ADDR_FALL: word_d = word_code;
            ST_DATA_SET:  word_d = word_data;
            ST_DATA_RISE: begin
                ctrl_d[CTRL_STB_BIT] = 1'b1;
                word_d = word_data;
            end
            ST_STB_END:   word_d = word_data;
            ST_DONE:      done_d = 1'b1;
            default:      busy_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tst_ctrl_o <= '0;
            tst_word_o <= '0;
            busy_o     <= 1'b0;
            done_o     <= 1'b0;
        end else begin
            tst_ctrl_o <= ctrl_d;
            tst_word_o <= word_d;
            busy_o     <= busy_d;
            done_o     <= done_d;
        end
    end

endmodule

// File: rtl/phy_test_writer.sv
module phy_test_writer
    import ptw_pkg::*;
#(
    parameter int CODE_W      = 8,
    parameter int DATA_W      = 8,
    parameter int EN_BIT      = 16,
    parameter int STEP_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [1:0]        tst_ctrl_o,
    output logic [EN_BIT:0]   tst_word_o,
    output logic              busy_o,
    output logic              done_o
);

    localparam int OPND_W = (CODE_W > DATA_W) ? CODE_W : DATA_W;

    logic              load, run, step_last;
    logic [CODE_W-1:0] code_q;
    logic [DATA_W-1:0] data_q;

    ptw_operand_reg #(
        .CODE_W (CODE_W),
        .DATA_W (DATA_W)
    ) u_opnd (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .code_i (code_i),
        .data_i (data_i),
        .code_q (code_q),
        .data_q (data_q)
    );

    ptw_step_timer #(
        .STEP_CYCLES (STEP_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .last_o (step_last)
    );

    ptw_seq_fsm #(
        .CODE_W (CODE_W),
        .DATA_W (DATA_W),
        .OPND_W (OPND_W),
        .EN_BIT (EN_BIT)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .step_last_i (step_last),
        .code_q      (code_q),
        .data_q      (data_q),
        .run_o       (run),
        .load_o      (load),
        .tst_ctrl_o  (tst_ctrl_o),
        .tst_word_o  (tst_word_o),
        .busy_o      (busy_o),
        .done_o      (done_o)
    );

endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
    parameter int EN_BIT = 16,
    parameter int OPND_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      tst_ctrl_o,
    input logic [EN_BIT:0] tst_word_o,
    input logic            busy_o,
    input logic            done_o
);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (tst_ctrl_o == 2'b00) && (tst_word_o == '0));

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6
    done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o && (tst_ctrl_o == 2'b00) && (tst_word_o == '0));

    // R3
    fall_holds_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tst_ctrl_o[1]) |-> $stable(tst_word_o));

    // R4
    rise_no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tst_ctrl_o[1]) |-> !tst_word_o[EN_BIT] && $stable(tst_word_o));

    // R2
    clear_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tst_ctrl_o[0] |-> !tst_ctrl_o[1] && (tst_word_o == '0));

    // R8
    spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tst_word_o[EN_BIT-1:OPND_W] == '0);

    // R7
    busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

endmodule

bind phy_test_writer ptw_checker #(
    .EN_BIT (EN_BIT),
    .OPND_W (OPND_W)
) u_ptw_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .tst_ctrl_o (tst_ctrl_o),
    .tst_word_o (tst_word_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
);

// File: tb/test_phy_test_writer.sv
`timescale 1ns/1ps

module ptw_ref_mon #(
    parameter int STEP = 1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic [7:0]  code_i,
    input logic [7:0]  data_i,
    input logic [1:0]  tst_ctrl_o,
    input logic [16:0] tst_word_o,
    input logic        busy_o,
    input logic        done_o
);

    typedef struct packed {
        logic [1:0]  ctrl;
        logic [16:0] word;
        logic        busy;
        logic        done;
        logic [3:0]  ph;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails  = 0;
    exp_t e;
    bit   was_idle;
    string tag;

    function automatic exp_t step_val(input int s, input logic [7:0] c, input logic [7:0] d);
        exp_t r;
        r = '0;
        r.busy = 1'b1;
        r.ph = 4'(s);
        case (s)
            0: r.ctrl = 2'b01;                                  // clear pulse
            1: ;                                                // clear dropped
            2: r.ctrl = 2'b10;                                  // strobe up
            3: begin r.ctrl = 2'b10; r.word = {1'b1, 8'h00, c}; end
            4: r.word = {1'b1, 8'h00, c};                       // falling edge
            5: r.word = {1'b0, 8'h00, d};
            6: begin r.ctrl = 2'b10; r.word = {1'b0, 8'h00, d}; end
            7: r.word = {1'b0, 8'h00, d};
            default: begin r.done = 1'b1; end
        endcase
        return r;
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            q.delete();
            e = '0;
            tag = "R1";
            was_idle = 1'b1;
        end else begin
            was_idle = (q.size() == 0);
            if (was_idle) e = '0;
            else          e = q.pop_front();
            tag = "";
        end
        checks++;
        if (tst_ctrl_o !== e.ctrl || tst_word_o !== e.word ||
            busy_o !== e.busy || done_o !== e.done) begin
            if (!rst_n)                                      tag = "R1";
            else if (done_o !== e.done || busy_o !== e.busy) tag = "R6";
            else if (tst_word_o[15:8] !== 8'h00)              tag = "R8";
            else if (was_idle)                                tag = "R7";
            else if (e.ph <= 1)                               tag = "R2";
            else if (e.ph <= 4)                               tag = "R3";
            else                                              tag = "R4";
            fails++;
            $display("FAIL %s step=%0d t=%0t: ctrl=%b word=%h busy=%b done=%b expected ctrl=%b word=%h busy=%b done=%b",
                     tag, STEP, $time, tst_ctrl_o, tst_word_o, busy_o, done_o,
                     e.ctrl, e.word, e.busy, e.done);
        end
        // R9: operands taken as sampled at the accepting edge
        if (rst_n && was_idle && start_i) begin
            for (int s = 0; s < 8; s++)
                for (int k = 0; k < STEP; k++)   // R5: each step STEP cycles
                    q.push_back(step_val(s, code_i, data_i));
            q.push_back(step_val(8, code_i, data_i));
        end
    end

endmodule

module test_phy_test_writer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  code = 8'h00;
    logic [7:0]  data = 8'h00;

    logic [1:0]  ctrl_a, ctrl_b;
    logic [16:0] word_a, word_b;
    logic        busy_a, busy_b, done_a, done_b;
    int          wd_fail = 0;
    int          cyc_cnt = 0;
    bit          finished = 0;

    always #2.5 clk = ~clk;

    phy_test_writer #(.STEP_CYCLES(3)) i_phy_test_writer (
        .clk(clk), .rst_n(rst_n), .start_i(start), .code_i(code), .data_i(data),
        .tst_ctrl_o(ctrl_a), .tst_word_o(word_a), .busy_o(busy_a), .done_o(done_a)
    );

    phy_test_writer #(.STEP_CYCLES(1)) i_phy_test_writer_fast (
        .clk(clk), .rst_n(rst_n), .start_i(start), .code_i(code), .data_i(data),
        .tst_ctrl_o(ctrl_b), .tst_word_o(word_b), .busy_o(busy_b), .done_o(done_b)
    );

    ptw_ref_mon #(.STEP(3)) i_mon_a (
        .clk(clk), .rst_n(rst_n), .start_i(start), .code_i(code), .data_i(data),
        .tst_ctrl_o(ctrl_a), .tst_word_o(word_a), .busy_o(busy_a), .done_o(done_a)
    );

    ptw_ref_mon #(.STEP(1)) i_mon_b (
        .clk(clk), .rst_n(rst_n), .start_i(start), .code_i(code), .data_i(data),
        .tst_ctrl_o(ctrl_b), .tst_word_o(word_b), .busy_o(busy_b), .done_o(done_b)
    );

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d",
                     i_mon_a.checks + i_mon_b.checks + 1,
                     i_mon_a.fails + i_mon_b.fails + wd_fail);
            $finish;
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic launch(input logic [7:0] c, input logic [7:0] d);
        start = 1'b1; code = c; data = d;
        cyc(1);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        cyc(1);
        while (busy_a || busy_b) cyc(1);
    endtask

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 20000) begin
            wd_fail = 1;
            $display("FAIL watchdog: cycles=%0d expected below 20000", cyc_cnt);
            summary();
        end
    end

    initial begin
        // R1: outputs zero under reset, sampled by the monitors
        cyc(4);
        rst_n = 1'b1;
        cyc(3);
        // R2 R3 R4 R5 R6: band setting write
        launch(ptw_pkg::FREQ_RANGE_CODE, 8'h2C);
        wait_idle();
        // R8: all-ones operands reach only the low field
        launch(8'hFF, 8'hFF);
        wait_idle();
        launch(8'h00, 8'h00);
        wait_idle();
        // R7: start pulse while busy; R9: operand inputs change mid-write
        launch(8'hA5, 8'h5A);
        cyc(2);
        start = 1'b1; code = 8'h99; data = 8'h77;
        cyc(1);
        start = 1'b0; code = 8'h3C; data = 8'hC3;
        cyc(5);
        code = 8'h01; data = 8'h80;
        wait_idle();
        cyc(3);
        // R10: start held high, back-to-back writes
        start = 1'b1; code = 8'h12; data = 8'h34;
        cyc(60);
        start = 1'b0;
        wait_idle();
        // R7: start in the done cycle of the slow copy is ignored
        launch(8'h5A, 8'hA5);
        while (!done_a) cyc(1);
        start = 1'b1; code = 8'hEE; data = 8'hDD;
        cyc(1);
        start = 1'b0;
        wait_idle();
        cyc(5);
        if (i_mon_a.checks < 12 || i_mon_b.checks < 12) begin
            wd_fail++;
            $display("FAIL R6: checks a=%0d b=%0d expected at least 12",
                     i_mon_a.checks, i_mon_b.checks);
        end
        summary();
    end

endmodule